// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-on to an idle, fully initialized state. After reset it holds the clock-enable pin low while the clock runs for a stabilization interval. The length of that interval is set in microseconds and converted to cycles from the clock-frequency parameter. It then raises clock enable with a NOP and issues a fixed series of commands: a precharge to all banks, an extended mode write that turns the DLL on, a mode write that resets the DLL, a second precharge, a parameterized number of auto-refreshes, and a last mode write that programs the operating mode with the DLL-reset bit clear. Each command is followed by its minimum gap (row-precharge time, refresh cycle time, or the mode-write gap). Every other cycle carries NOP.

The done flag rises only after two conditions hold: the last mode-write gap has elapsed, and the DLL lock window has run out. That window is counted from the DLL-reset command. When the clock frequency changes, the system pulses a re-initialize input. While initialization is complete, this drops the done flag, issues a fresh DLL-reset mode write and waits through a new lock window before done rises again.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `cke` is low for exactly CLK_MHZ*STABLE_US cycles and the command bus carries NOP; `init_done` is low.
- R2: `cke` rises in a cycle that carries NOP, stays high afterwards, and the first command (precharge-all) appears in the next cycle.
- R3: Command order is precharge-all, extended mode write, mode write with DLL reset, precharge-all, N_REFRESH auto-refreshes, mode write with DLL reset clear. The encodings on {cs_n,ras_n,cas_n,we_n} are NOP 0111, precharge 0010, auto-refresh 0001 and mode write 0000.
- R4: The next command starts exactly T_RP cycles after a precharge, T_RFC cycles after a refresh and T_MRD cycles after any mode write. A command is never followed by another command in the next cycle.
- R5: Precharge drives address bit 10 high and all other address bits low. The extended mode write drives `ba`=1 and `addr`=EMR_VAL with bit 0 cleared (DLL enabled). Both mode writes drive `ba`=0 and `addr`=MR_VAL, with bit 8 set for the DLL-reset write and cleared for the final write.
- R6: `init_done` first rises exactly at max(t_final + T_MRD, t_dllrst + DLL_LOCK), where t is the cycle of the named command. It then stays high and the bus carries NOP.
- R7: Every cycle that is not a sequence command drives NOP with `cs_n` low; no other encoding ever appears.
- R8: A `reinit_req` sampled while `init_done` is high lowers `init_done` in the next cycle. That same cycle carries a mode write with `ba`=0 and address MR_VAL with bit 8 set, and no other command follows. `init_done` returns max(T_MRD, DLL_LOCK) cycles after that command.
- R9: `reinit_req` has no effect while `init_done` is low; the command series and its timing are unchanged.
- R10: Asserting reset partway through the sequence restarts it from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit_req | input | 1 | Request to repeat the DLL reset after a frequency change |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address (selects base or extended mode register) |
| addr | output | ADDR_W | Address bus (mode value, precharge-all bit) |
| init_done | output | 1 | Initialization complete |

## Verification
The bench logs every non-NOP command with its cycle and compares order, fields and exact spacing against a schedule it computes itself. A gap counter off by one would show up as spacing one cycle too long or too short. Swapping the base and extended bank select or leaving bit 8 set in the final write would show up as a field mismatch. Done is checked at the exact cycle given by whichever of the lock window and the last mode-write gap ends later, so a design that ignores the lock timer raises done about 177 cycles early. Random re-initialize pulses during bring-up must leave the schedule unchanged, and a design that honours them would restart the DLL reset midway. Pulses after completion must yield a single DLL-reset write and a full new lock window. A mid-sequence reset must bring clock enable low again.

// File: rtl/ddr_init_pkg.sv
// Package: shared state and step encodings for the DDR init sequencer.
// Assumes: used by ddr_init_seq and ddr_init_cmd_enc only.
package ddr_init_pkg;

    // Top-level phase of the bring-up
    typedef enum logic [2:0] {
        ST_STABLE,  // cke low, waiting for clock stabilization
        ST_CKE,     // cke raised, NOP cycle
        ST_CMD,     // issuing the command selected by the step
        ST_GAP,     // NOP cycles until the command gap expires
        ST_LOCK,    // waiting for the DLL lock window
        ST_DONE     // initialized, idle
    } seq_state_t;

    // Which command of the series is current
    typedef enum logic [2:0] {
        STEP_PRE1,
        STEP_EMRS,
        STEP_DLLRST,
        STEP_PRE2,
        STEP_REF,
        STEP_MRS_OP
    } step_t;

    localparam int DLL_RST_BIT = 8;   // mode register bit that resets the DLL
    localparam int ALL_BANK_BIT = 10; // address bit that selects all banks on precharge

endpackage

// File: rtl/ddr_init_timer.sv
// Module: saturating down-counter used for the stabilization wait, command
// gaps and the DLL lock window.
// Assumes: load has priority over counting; the count stops at zero.
module ddr_init_timer #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);

    logic [W-1:0] cnt;

    // Count down toward zero, reloading on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);

    // R4: an unloaded, non-zero count steps down by exactly one
    a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !is_zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
// Module: turns the current step into command pins, bank and address.
// Assumes: issue is high for exactly one cycle per command; NOP otherwise.
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W = 2,
    parameter logic [ADDR_W-1:0] EMR_VAL = '0,
    parameter logic [ADDR_W-1:0] MR_VAL = '0
) (
    input  logic              issue,
    input  step_t             step,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] DLL_BIT = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] AP_BIT  = ADDR_W'(1) << ALL_BANK_BIT;
    localparam logic [ADDR_W-1:0] EMR_DLL_ON = EMR_VAL & ~ADDR_W'(1);

    // Decode step into the four-pin command and its operands
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        ba   = '0;
        addr = '0;
        if (issue) begin
            case (step)
                STEP_PRE1, STEP_PRE2: begin
                    {cs_n, ras_n, cas_n, we_n} = 4'b0010;
                    addr = AP_BIT;
                end
                STEP_EMRS: begin
                    {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                    ba   = BA_W'(1);
                    addr = EMR_DLL_ON;
                end
                STEP_DLLRST: begin
                    {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                    addr = MR_VAL | DLL_BIT;
                end
                STEP_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
                STEP_MRS_OP: begin
                    {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                    addr = MR_VAL & ~DLL_BIT;
                end
                default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            endcase
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Module: DDR SDRAM power-up initialization sequencer (top).
// Runs the stabilization wait, raises cke, issues the fixed command series
// with its minimum gaps, waits for DLL lock and then flags completion.
// A reinit request after completion repeats the DLL reset and lock wait.
// Assumes: T_RP, T_RFC, T_MRD and DLL_LOCK are all at least 2; ADDR_W > 10.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int STABLE_US = 200,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int T_MRD     = 2,
    parameter int DLL_LOCK  = 200,
    parameter int N_REFRESH = 2,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter logic [ADDR_W-1:0] EMR_VAL = 13'h0002,
    parameter logic [ADDR_W-1:0] MR_VAL  = 13'h0032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int GAP_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int CNT_MAX = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int LOCK_W  = $clog2(DLL_LOCK + 1);
    localparam int RC_W    = $clog2(N_REFRESH + 1);

    seq_state_t       state;
    step_t            step;
    logic [RC_W-1:0]  ref_cnt;
    logic             reinit_mode;
    logic             issue;
    logic             gap_zero;
    logic             lock_zero;
    logic             lock_load;
    logic             is_last;
    logic [CNT_W-1:0] gap_val;

    // Gap (minus the issue and final cycles) that follows the current command
    always_comb begin
        case (step)
            STEP_PRE1, STEP_PRE2: gap_val = CNT_W'(T_RP - 2);
            STEP_REF:             gap_val = CNT_W'(T_RFC - 2);
            default:              gap_val = CNT_W'(T_MRD - 2);
        endcase
    end

    assign issue     = (state == ST_CMD);
    assign lock_load = issue && (step == STEP_DLLRST);
    assign is_last   = (step == STEP_MRS_OP) || (step == STEP_DLLRST && reinit_mode);
    assign cke       = (state != ST_STABLE);
    assign init_done = (state == ST_DONE);

    ddr_init_timer #(
        .W       (CNT_W),
        .RST_VAL (CNT_W'(STABLE_CYC - 1))
    ) u_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .load_val (gap_val),
        .is_zero  (gap_zero)
    );

    ddr_init_timer #(
        .W       (LOCK_W),
        .RST_VAL ('0)
    ) u_lock_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .load_val (LOCK_W'(DLL_LOCK - 2)),
        .is_zero  (lock_zero)
    );

    // Sequence state machine: phase, current step and refresh tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_STABLE;
            step        <= STEP_PRE1;
            ref_cnt     <= '0;
            reinit_mode <= 1'b0;
        end else begin
            case (state)
                ST_STABLE: if (gap_zero) state <= ST_CKE;
                ST_CKE:    state <= ST_CMD;
                ST_CMD: begin
                    state <= ST_GAP;
                    if (step == STEP_REF) ref_cnt <= ref_cnt + 1'b1;
                end
                ST_GAP: begin
                    if (gap_zero) begin
                        if (is_last) begin
                            state <= lock_zero ? ST_DONE : ST_LOCK;
                        end else begin
                            state <= ST_CMD;
                            case (step)
                                STEP_PRE1:   step <= STEP_EMRS;
                                STEP_EMRS:   step <= STEP_DLLRST;
                                STEP_DLLRST: step <= STEP_PRE2;
                                STEP_PRE2:   step <= STEP_REF;
                                STEP_REF:    step <= (ref_cnt == RC_W'(N_REFRESH)) ? STEP_MRS_OP
                                                                                   : STEP_REF;
                                default:     step <= STEP_MRS_OP;
                            endcase
                        end
                    end
                end
                ST_LOCK: if (lock_zero) state <= ST_DONE;
                ST_DONE: begin
                    if (reinit_req) begin
                        state       <= ST_CMD;
                        step        <= STEP_DLLRST;
                        reinit_mode <= 1'b1;
                    end
                end
                default: state <= ST_STABLE;
            endcase
        end
    end

    ddr_init_cmd_enc #(
        .ADDR_W  (ADDR_W),
        .BA_W    (BA_W),
        .EMR_VAL (EMR_VAL),
        .MR_VAL  (MR_VAL)
    ) u_cmd_enc (
        .issue (issue),
        .step  (step),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    // R1: while cke is low only NOP appears on the bus
    a_r1_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R2: once raised, cke stays high
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R4: a command is always followed by a NOP cycle
    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        ({ras_n, cas_n, we_n} != 3'b111) |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R6: completion only after the DLL lock window, with an idle bus
    a_r6_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (lock_zero && {cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R8: a reinit request while done drops done and issues the DLL-reset write
    a_r8_reinit_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && reinit_req) |=> (!init_done && !ras_n && !cas_n && !we_n
                                       && addr[DLL_RST_BIT] && ba == '0));

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

    localparam int CLK_MHZ = 50, STABLE_US = 200;
    localparam int T_RP = 3, T_RFC = 8, T_MRD = 2, DLL_LOCK = 200, N_REF = 2;
    localparam int AW = 13, BW = 2;
    localparam logic [AW-1:0] EMR = 13'h0002;
    localparam logic [AW-1:0] MR  = 13'h0032;
    localparam int S = CLK_MHZ * STABLE_US;
    localparam int NCMD = 5 + N_REF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reinit_req = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    always #10 clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK), .N_REFRESH(N_REF),
        .ADDR_W(AW), .BA_W(BW), .EMR_VAL(EMR), .MR_VAL(MR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .reinit_req(reinit_req), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    int total = 0, bad = 0, cyc = 0, c0 = 0;
    int lg_kind[32], lg_cyc[32], lg_ba[32], lg_addr[32];
    int lg_n, cke_low_n, cke_rise, done_cyc, fall_cyc, odd_n;
    bit prev_done;

    always @(posedge clk) cyc <= cyc + 1;

    // 0 NOP, 1 precharge, 2 refresh, 3 mode write, 9 anything else
    function automatic int kind_of(logic [3:0] p);
        case (p)
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 9;
        endcase
    endfunction

    function automatic int gap_of(int k);
        if (k == 1) return T_RP;
        if (k == 2) return T_RFC;
        return T_MRD;
    endfunction

    function automatic int exp_kind(int i);
        if (i == 0 || i == 3) return 1;
        if (i == 1 || i == 2 || i == NCMD - 1) return 3;
        return 2;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // done offset from the first precharge under the nominal schedule
    function automatic int nominal_done();
        int t_rst, t_op;
        t_rst = T_RP + T_MRD;
        t_op  = 2 * T_RP + 2 * T_MRD + N_REF * T_RFC;
        return max2(t_op + T_MRD, t_rst + DLL_LOCK);
    endfunction

    // Monitor: logs commands and edges of cke/done, sampled mid-cycle
    always @(negedge clk) begin
        int k;
        k = kind_of({cs_n, ras_n, cas_n, we_n});
        if (rst_n) begin
            if (!cke) cke_low_n++;
            else if (cke_rise < 0) cke_rise = cyc;
            if (k == 9) odd_n++;
            if (k != 0 && lg_n < 32) begin
                lg_kind[lg_n] = k; lg_cyc[lg_n] = cyc;
                lg_ba[lg_n] = int'(ba); lg_addr[lg_n] = int'(addr);
                lg_n++;
            end
            if (init_done && !prev_done) done_cyc = cyc;
            if (!init_done && prev_done) fall_cyc = cyc;
        end
        prev_done = init_done;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        lg_n = 0; cke_low_n = 0; cke_rise = -1; done_cyc = -1; fall_cyc = -1; odd_n = 0;
    endtask

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0; reinit_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cke == 1'b0 && init_done == 1'b0, "R10", "reset state cke/done",
            int'({cke, init_done}), 0);
        chk(kind_of({cs_n, ras_n, cas_n, we_n}) == 0, "R1", "bus in reset",
            kind_of({cs_n, ras_n, cas_n, we_n}), 0);
        @(posedge clk);
        clear_log();
        #2 rst_n = 1'b1;
        c0 = cyc;
    endtask

    // Full bring-up with optional random reinit noise (R9)
    task automatic run_init(int noisy);
        int n = 0;
        do_reset();
        while (done_cyc < 0 && n < S + 2000) begin
            @(posedge clk); #2;
            reinit_req = (n < noisy) && ($urandom % 16 == 0);
            n++;
        end
        reinit_req = 1'b0;
        @(negedge clk);
        chk(cke_low_n == S, "R1", "cycles with cke low", cke_low_n, S);
        chk(cke_rise == c0 + S, "R2", "cke rise cycle", cke_rise, c0 + S);
        chk(lg_n == NCMD, "R3", "command count", lg_n, NCMD);
        chk(odd_n == 0, "R7", "non-NOP idle encodings", odd_n, 0);
        if (lg_n == NCMD) begin
            chk(lg_cyc[0] == cke_rise + 1, "R2", "first command cycle", lg_cyc[0], cke_rise + 1);
            for (int i = 0; i < NCMD; i++) begin
                chk(lg_kind[i] == exp_kind(i), "R3", "command kind", lg_kind[i], exp_kind(i));
                if (i + 1 < NCMD)
                    chk(lg_cyc[i+1] - lg_cyc[i] == gap_of(lg_kind[i]), "R4", "command spacing",
                        lg_cyc[i+1] - lg_cyc[i], gap_of(lg_kind[i]));
                if (lg_kind[i] == 1)
                    chk(lg_addr[i] == 1024, "R5", "precharge address", lg_addr[i], 1024);
            end
            chk(lg_ba[1] == 1, "R5", "ext mode bank", lg_ba[1], 1);
            chk(lg_addr[1] == int'(EMR & ~13'h1), "R5", "ext mode value", lg_addr[1],
                int'(EMR & ~13'h1));
            chk(lg_ba[2] == 0 && lg_addr[2] == int'(MR | 13'h100), "R5", "dll reset write",
                lg_addr[2], int'(MR | 13'h100));
            chk(lg_ba[NCMD-1] == 0 && lg_addr[NCMD-1] == int'(MR & ~13'h100), "R5",
                "final mode write", lg_addr[NCMD-1], int'(MR & ~13'h100));
            chk(done_cyc == max2(lg_cyc[NCMD-1] + T_MRD, lg_cyc[2] + DLL_LOCK), "R6",
                "done cycle", done_cyc, max2(lg_cyc[NCMD-1] + T_MRD, lg_cyc[2] + DLL_LOCK));
        end
        if (noisy > 0)
            chk(done_cyc == c0 + S + 1 + nominal_done(), "R9", "schedule under reinit noise",
                done_cyc, c0 + S + 1 + nominal_done());
        repeat (5) @(negedge clk);
        chk(init_done == 1'b1 && lg_n == NCMD, "R6", "done holds, bus idle", lg_n, NCMD);
    endtask

    // Single reinit pulse after completion (R8)
    task automatic reinit_once();
        int t_req, n = 0;
        repeat (3 + $urandom % 40) @(posedge clk);
        clear_log();
        #2 reinit_req = 1'b1; t_req = cyc;
        @(posedge clk); #2 reinit_req = 1'b0;
        while (done_cyc < 0 && n < DLL_LOCK + 100) begin
            @(negedge clk); n++;
        end
        chk(lg_n == 1, "R8", "commands on reinit", lg_n, 1);
        chk(fall_cyc == t_req + 1, "R8", "done fall cycle", fall_cyc, t_req + 1);
        if (lg_n >= 1) begin
            chk(lg_kind[0] == 3 && lg_ba[0] == 0 && lg_addr[0] == int'(MR | 13'h100), "R8",
                "reinit dll reset write", lg_addr[0], int'(MR | 13'h100));
            chk(lg_cyc[0] == t_req + 1, "R8", "reinit command cycle", lg_cyc[0], t_req + 1);
        end
        chk(done_cyc == t_req + 1 + max2(T_MRD, DLL_LOCK), "R8", "done return cycle",
            done_cyc, t_req + 1 + max2(T_MRD, DLL_LOCK));
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0D0E));
        clear_log();
        run_init(0);
        for (int r = 0; r < 3; r++) reinit_once();
        run_init(S + 40);
        // R10: reset midway through the command series, then a clean run
        do_reset();
        repeat (S + 12) @(posedge clk);
        run_init(0);
        reinit_once();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule